// File: doc/BRIEF.md
# Display Controller Command Byte Parser

This block sits behind the serial receiver of a small greyscale panel controller. Each incoming byte arrives with a level that says whether it is pixel data or part of a command. Pixel bytes are passed straight through to the address stepper. Command bytes are gathered into an opcode followed by a variable number of argument bytes, from none up to eight. The count depends on the opcode. Once the last argument arrives, the command takes effect.

Accepted commands drive one of several outputs. A window command pulses a column or row load strobe and presents the start and end values beside it. The remap command updates a held remap byte, and one bit of that byte selects vertical address stepping. The grey-level command presents its eight argument bytes as one wide word with a load strobe. Commands that are recognised but have no effect here produce a single "ignored" pulse. An opcode missing from the table produces an error pulse, keeps a copy of the offending byte and frees the parser for the next opcode. One filler opcode locks the parser into swallowing command bytes until reset.

Top module: `oled_cmd_parser`

## Requirements
- R1: A byte with `byteValid`=1 and `dataSel`=1 appears on `pixByte` with `pixValid`=1 in the cycle after it is accepted, and it raises no command output.
- R2: Opcode 0x15 followed by two arguments pulses `colLoad` for one cycle after the second argument, with `winStart` = first argument and `winEnd` = second argument.
- R3: Opcode 0x75 followed by two arguments pulses `rowLoad` for one cycle after the second argument, with `winStart` = first argument and `winEnd` = second argument.
- R4: Opcode 0xA0 with one argument loads `remapReg` with that argument; `vertInc` equals bit 2 of `remapReg`, and `remapReg` changes at no other time.
- R5: Opcodes 0x81, 0xA1, 0xA2, 0xA8, 0xAD, 0xB1, 0xB2, 0xB3, 0xBC, 0xBE and 0xBF each consume one argument and then pulse `ignorePulse` once.
- R6: Opcodes 0x84, 0x85, 0x86, 0xA4, 0xA5, 0xA6, 0xA7, 0xAE, 0xAF and 0xE3 take no argument and pulse `ignorePulse` in the cycle after the opcode.
- R7: Opcode 0xB8 consumes eight arguments and then pulses `greyLoad`; argument k (counting from 0) is placed at `greyTable[8k+7:8k]`.
- R8: An opcode not listed in R2 to R7 or R9 pulses `errPulse` for one cycle and loads `errOpcode` with it. `errOpcode` then holds until the next error. The following command byte is treated as a new opcode.
- R9: After opcode 0xFF, every later command byte is consumed with no output until reset, while data bytes are still forwarded as in R1.
- R10: Changing `dataSel` between the bytes of a command does not discard the arguments already gathered.
- R11: After reset all pulse outputs are 0 and `winStart`, `winEnd`, `remapReg`, `greyTable` and `errOpcode` are 0.
- R12: No command output fires before the final argument of a command; at most one of `colLoad`, `rowLoad`, `greyLoad`, `ignorePulse`, `errPulse` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| byteValid | input | 1 | A byte is presented this cycle |
| dataSel | input | 1 | 1 = pixel data, 0 = command stream |
| byteIn | input | 8 | Incoming byte |
| pixValid | output | 1 | Forwarded pixel byte valid |
| pixByte | output | 8 | Forwarded pixel byte |
| colLoad | output | 1 | Column window load pulse |
| rowLoad | output | 1 | Row window load pulse |
| winStart | output | 8 | Window start value |
| winEnd | output | 8 | Window end value |
| remapReg | output | 8 | Held remap byte |
| vertInc | output | 1 | Vertical address step select |
| greyLoad | output | 1 | Grey-level table load pulse |
| greyTable | output | 64 | Grey-level table, argument k in bits 8k+7:8k |
| ignorePulse | output | 1 | Recognised command with no effect completed |
| errPulse | output | 1 | Unknown opcode seen |
| errOpcode | output | 8 | Last unknown opcode |

## Verification
A wrong byte count shows up at the next command boundary. If the count stops early, an argument byte is decoded as an opcode, and that usually ends in `errPulse` or in a strobe one byte too soon. If the count runs late, the strobe of the following command goes missing. A slot index that is off by one shows in `winStart` or in the ordering of `greyTable` in the same cycle as the load pulse. A counter left non-zero after an error or a mode switch is exposed by the next opcode in the table walk. The filler lockout is checked by sending known-good opcodes after it and watching for silence.

// File: rtl/ocp_pkg.sv
package ocp_pkg;
  localparam int MAX_ARGS = 8;
  localparam int CNT_W    = $clog2(MAX_ARGS + 1);
  localparam int SLOT_W   = $clog2(MAX_ARGS);

  typedef enum logic [2:0] {
    CL_COL, CL_ROW, CL_REMAP, CL_IGNORE, CL_GREY, CL_FILL, CL_BAD
  } opClass_e;

  typedef struct packed {
    opClass_e          cls;
    logic [CNT_W-1:0]  need;
  } opInfo_t;

  typedef struct packed {
    logic              storeArg;
    logic [SLOT_W-1:0] slot;
    logic              loadCol;
    logic              loadRow;
    logic              loadRemap;
    logic              loadGrey;
    logic              ignore;
    logic              err;
  } strobe_t;

  // Argument-count table
  function automatic opInfo_t lookupOp(input logic [7:0] op);
    opInfo_t r;
    r.cls  = CL_BAD;
    r.need = '0;
    case (op)
      8'h15: begin r.cls = CL_COL;   r.need = CNT_W'(2); end
      8'h75: begin r.cls = CL_ROW;   r.need = CNT_W'(2); end
      8'hA0: begin r.cls = CL_REMAP; r.need = CNT_W'(1); end
      8'h81, 8'hA1, 8'hA2, 8'hA8, 8'hAD, 8'hB1, 8'hB2, 8'hB3,
      8'hBC, 8'hBE, 8'hBF:
             begin r.cls = CL_IGNORE; r.need = CNT_W'(1); end
      8'h84, 8'h85, 8'h86, 8'hA4, 8'hA5, 8'hA6, 8'hA7, 8'hAE,
      8'hAF, 8'hE3:
             begin r.cls = CL_IGNORE; r.need = '0; end
      8'hB8: begin r.cls = CL_GREY;  r.need = CNT_W'(MAX_ARGS); end
      8'hFF: begin r.cls = CL_FILL;  r.need = '0; end
      default: ;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/ocp_ctrl.sv
module ocp_ctrl
  import ocp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       byteValid,
  input  logic       dataSel,
  input  logic [7:0] byteIn,
  output strobe_t    st
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] needCnt;
  opClass_e         opClass;
  opInfo_t          info;
  logic             cmdByte;

  assign cmdByte = byteValid && !dataSel;
  assign info    = lookupOp(byteIn);

  function automatic strobe_t fire(input strobe_t s, input opClass_e c);
    strobe_t o = s;
    case (c)
      CL_COL:    o.loadCol   = 1'b1;
      CL_ROW:    o.loadRow   = 1'b1;
      CL_REMAP:  o.loadRemap = 1'b1;
      CL_GREY:   o.loadGrey  = 1'b1;
      CL_IGNORE: o.ignore    = 1'b1;
      default: ;
    endcase
    return o;
  endfunction

  always_comb begin
    st = '0;
    if (cmdByte) begin
      if (cnt == '0) begin
        if (info.cls == CL_BAD)
          st.err = 1'b1;
        else if (info.cls != CL_FILL && info.need == '0)
          st = fire(st, info.cls);
      end else if (opClass != CL_FILL) begin
        st.storeArg = 1'b1;
        st.slot     = SLOT_W'(cnt - CNT_W'(1));
        if (cnt == needCnt)
          st = fire(st, opClass);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt     <= '0;
      needCnt <= '0;
      opClass <= CL_BAD;
    end else if (cmdByte) begin
      if (cnt == '0) begin
        if (info.cls == CL_FILL || (info.cls != CL_BAD && info.need != '0)) begin
          cnt     <= CNT_W'(1);
          needCnt <= info.need;
          opClass <= info.cls;
        end
      end else if (opClass != CL_FILL) begin
        if (cnt == needCnt) cnt <= '0;
        else                cnt <= cnt + CNT_W'(1);
      end
    end
  end

  // R1
  pix_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (byteValid && dataSel) |-> (st == '0));

  // R8
  err_reset_cnt_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.err |=> (cnt == '0));

  // R9
  fill_stuck_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cnt != '0 && opClass == CL_FILL) |=> (cnt != '0 && opClass == CL_FILL));
endmodule

// File: rtl/ocp_datapath.sv
module ocp_datapath
  import ocp_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  byteValid,
  input  logic                  dataSel,
  input  logic [7:0]            byteIn,
  input  strobe_t               st,
  output logic                  pixValid,
  output logic [7:0]            pixByte,
  output logic                  colLoad,
  output logic                  rowLoad,
  output logic [7:0]            winStart,
  output logic [7:0]            winEnd,
  output logic [7:0]            remapReg,
  output logic                  greyLoad,
  output logic [8*MAX_ARGS-1:0] greyTable,
  output logic                  ignorePulse,
  output logic                  errPulse,
  output logic [7:0]            errOpcode
);
  logic [7:0] argBuf [MAX_ARGS];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < MAX_ARGS; k++) argBuf[k] <= '0;
    end else if (st.storeArg) begin
      argBuf[st.slot] <= byteIn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pixValid    <= 1'b0;
      pixByte     <= '0;
      colLoad     <= 1'b0;
      rowLoad     <= 1'b0;
      greyLoad    <= 1'b0;
      ignorePulse <= 1'b0;
      errPulse    <= 1'b0;
      winStart    <= '0;
      winEnd      <= '0;
      remapReg    <= '0;
      errOpcode   <= '0;
    end else begin
      pixValid    <= byteValid && dataSel;
      if (byteValid && dataSel) pixByte <= byteIn;
      colLoad     <= st.loadCol;
      rowLoad     <= st.loadRow;
      greyLoad    <= st.loadGrey;
      ignorePulse <= st.ignore;
      errPulse    <= st.err;
      if (st.loadCol || st.loadRow) begin
        winStart <= argBuf[0];
        winEnd   <= byteIn;
      end
      if (st.loadRemap) remapReg  <= byteIn;
      if (st.err)       errOpcode <= byteIn;
    end
  end

  generate
    for (genvar g = 0; g < MAX_ARGS; g++) begin : gTable
      always_ff @(posedge clk) begin
        if (!rstN)
          greyTable[8*g +: 8] <= '0;
        else if (st.loadGrey)
          greyTable[8*g +: 8] <= (g == MAX_ARGS - 1) ? byteIn : argBuf[g];
      end
    end
  endgenerate

  // R12
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({colLoad, rowLoad, greyLoad, ignorePulse, errPulse}));

  // R4
  remap_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !st.loadRemap |=> $stable(remapReg));

  // R8
  err_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !errPulse |-> $stable(errOpcode));
endmodule

// File: rtl/oled_cmd_parser.sv
module oled_cmd_parser
  import ocp_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        byteValid,
  input  logic        dataSel,
  input  logic [7:0]  byteIn,
  output logic        pixValid,
  output logic [7:0]  pixByte,
  output logic        colLoad,
  output logic        rowLoad,
  output logic [7:0]  winStart,
  output logic [7:0]  winEnd,
  output logic [7:0]  remapReg,
  output logic        vertInc,
  output logic        greyLoad,
  output logic [63:0] greyTable,
  output logic        ignorePulse,
  output logic        errPulse,
  output logic [7:0]  errOpcode
);
  strobe_t st;

  ocp_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .dataSel(dataSel),
    .byteIn(byteIn), .st(st)
  );

  ocp_datapath u_dp (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .dataSel(dataSel),
    .byteIn(byteIn), .st(st),
    .pixValid(pixValid), .pixByte(pixByte),
    .colLoad(colLoad), .rowLoad(rowLoad),
    .winStart(winStart), .winEnd(winEnd), .remapReg(remapReg),
    .greyLoad(greyLoad), .greyTable(greyTable),
    .ignorePulse(ignorePulse), .errPulse(errPulse), .errOpcode(errOpcode)
  );

  assign vertInc = remapReg[2];
endmodule

// File: tb/sim_oled_cmd_parser.sv
module sim_oled_cmd_parser;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rstN, byteValid, dataSel;
  logic [7:0]  byteIn;
  logic        pixValid, colLoad, rowLoad, greyLoad, ignorePulse, errPulse, vertInc;
  logic [7:0]  pixByte, winStart, winEnd, remapReg, errOpcode;
  logic [63:0] greyTable;

  oled_cmd_parser u0 (.*);

  int total = 0, bad = 0;
  bit done = 0;

  // ev: 1 col R2, 2 row R3, 3 remap R4, 4 ignore one-arg R5, 5 grey R7, 6 err R8, 7 ignore zero-arg R6
  typedef struct packed {
    logic [7:0]  op;
    logic [3:0]  n;
    logic [63:0] args;
    logic [2:0]  ev;
    logic [63:0] val;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{8'h15, 4'd2, 64'h3A10, 3'd1, 64'h103A},
    '{8'h75, 4'd2, 64'h4F05, 3'd2, 64'h054F},
    '{8'hA0, 4'd1, 64'h04,   3'd3, 64'h04},
    '{8'h81, 4'd1, 64'h7F,   3'd4, 64'h0},
    '{8'hA4, 4'd0, 64'h0,    3'd7, 64'h0},
    '{8'hE3, 4'd0, 64'h0,    3'd7, 64'h0},
    '{8'hB8, 4'd8, 64'h0807060504030201, 3'd5, 64'h0807060504030201},
    '{8'h42, 4'd0, 64'h0,    3'd6, 64'h42},
    '{8'hBF, 4'd1, 64'h33,   3'd4, 64'h0},
    '{8'hA0, 4'd1, 64'hF0,   3'd3, 64'hF0},
    '{8'h86, 4'd0, 64'h0,    3'd7, 64'h0},
    '{8'h00, 4'd0, 64'h0,    3'd6, 64'h00}
  };

  function automatic logic [2:0] evNow();
    if (colLoad)     return 3'd1;
    if (rowLoad)     return 3'd2;
    if (ignorePulse) return 3'd4;
    if (greyLoad)    return 3'd5;
    if (errPulse)    return 3'd6;
    return 3'd0;
  endfunction

  function automatic logic [2:0] expStrobe(input logic [2:0] ev);
    case (ev)
      3'd3: return 3'd0;
      3'd7: return 3'd4;
      default: return ev;
    endcase
  endfunction

  function automatic string tagOf(input logic [2:0] ev);
    case (ev)
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      3'd5: return "R7";
      3'd6: return "R8";
      default: return "R6";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic sendByte(input logic sel, input logic [7:0] b);
    @(negedge clk);
    dataSel = sel; byteIn = b; byteValid = 1'b1;
    @(posedge clk);
    #2;
    byteValid = 1'b0;
  endtask

  task automatic doReset();
    rstN = 1'b0; byteValid = 1'b0; dataSel = 1'b0; byteIn = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk);
    #2;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    int early;
    doReset();
    // R11 reset state
    chk("R11 pulses", {59'd0, colLoad, rowLoad, greyLoad, ignorePulse, errPulse}, 64'd0);
    chk("R11 regs", {winStart, winEnd, remapReg, errOpcode}, 32'd0);
    chk("R11 grey", greyTable, 64'd0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      early = 0;
      sendByte(1'b0, VECS[i].op);
      if (VECS[i].n != 0 && evNow() != 0) early++;
      for (int k = 0; k < int'(VECS[i].n); k++) begin
        sendByte(1'b0, VECS[i].args[8*k +: 8]);
        if (k < int'(VECS[i].n) - 1 && evNow() != 0) early++;
      end
      chk("R12 no early strobe", 64'(early), 64'd0);
      chk(tagOf(VECS[i].ev), 64'(evNow()), 64'(expStrobe(VECS[i].ev)));
      case (VECS[i].ev)
        3'd1, 3'd2: chk(tagOf(VECS[i].ev), {48'd0, winStart, winEnd}, VECS[i].val);
        3'd3: begin
          chk("R4 remap", 64'(remapReg), VECS[i].val);
          chk("R4 vertInc", 64'(vertInc), 64'(VECS[i].val[2]));
        end
        3'd5: chk("R7 table", greyTable, VECS[i].val);
        3'd6: chk("R8 opcode", 64'(errOpcode), VECS[i].val);
        default: ;
      endcase
    end

    // R1 data forwarding
    sendByte(1'b1, 8'hC7);
    chk("R1 pix", {55'd0, pixValid, pixByte}, {55'd0, 1'b1, 8'hC7});
    chk("R1 quiet", 64'(evNow()), 64'd0);

    // R8 errOpcode holds across a good command
    sendByte(1'b0, 8'h5C);
    chk("R8 err", {55'd0, errPulse, errOpcode}, {55'd0, 1'b1, 8'h5C});
    sendByte(1'b0, 8'hE3);
    chk("R8 hold", {55'd0, errPulse, errOpcode}, {55'd0, 1'b0, 8'h5C});

    // R10 select change mid-command
    sendByte(1'b0, 8'h15);
    sendByte(1'b0, 8'h22);
    sendByte(1'b1, 8'hAB);
    chk("R10 pix mid", {55'd0, pixValid, pixByte}, {55'd0, 1'b1, 8'hAB});
    chk("R10 quiet", 64'(evNow()), 64'd0);
    sendByte(1'b0, 8'h33);
    chk("R10 col", {47'd0, colLoad, winStart, winEnd}, {47'd0, 1'b1, 8'h22, 8'h33});

    // R9 filler lockout
    early = 0;
    sendByte(1'b0, 8'hFF);
    if (evNow() != 0) early++;
    sendByte(1'b0, 8'hA4); if (evNow() != 0) early++;
    sendByte(1'b0, 8'h42); if (evNow() != 0) early++;
    sendByte(1'b0, 8'h15); if (evNow() != 0) early++;
    sendByte(1'b0, 8'h01); if (evNow() != 0) early++;
    sendByte(1'b0, 8'h02); if (evNow() != 0) early++;
    chk("R9 silent", 64'(early), 64'd0);
    chk("R9 errOpcode kept", 64'(errOpcode), 64'h5C);
    sendByte(1'b1, 8'h5A);
    chk("R9 pix", {55'd0, pixValid, pixByte}, {55'd0, 1'b1, 8'h5A});
    doReset();
    chk("R11 after lockout", 64'(errOpcode), 64'd0);
    sendByte(1'b0, 8'hA4);
    chk("R9 recovered", 64'(evNow()), 64'd4);

    finishRun();
  end
endmodule